// File: doc/BRIEF.md
# Predicated Pairwise Floating-Point Maximum Unit

This block is a vector datapath that takes the larger value of each pair of neighbouring floating-point elements. It works on two source vectors and writes its result over the first one. Even output lanes take their pair from the first source and odd output lanes from the second, so the two sets of results come out interleaved. A per-byte predicate mask decides which lanes are written. Lanes that are not written keep their first-source value.

Elements are half, single or double precision, chosen by a 2-bit size code. The comparison follows the IEEE 754-2008 maxNum rule: a quiet NaN loses to a number, and a signalling NaN or a pair of NaNs gives the default quiet NaN and raises an invalid flag. The inputs are captured on a valid strobe, and the merged vector appears with a done strobe one clock later.

Top module: `pairmax_unit`

## Requirements
- R1: `size_code` selects the element width: 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit elements, with VEC_W/width lanes. Lane e occupies bits [e*width +: width].
- R2: An active even lane e gets the maximum of first-source elements e and e+1.
- R3: An active odd lane e gets the maximum of second-source elements e-1 and e.
- R4: Lane e is active when predicate bit e*(width/8) is 1. The other predicate bits have no effect. An inactive lane outputs its first-source element unchanged.
- R5: When one operand is a quiet NaN (exponent all ones, top mantissa bit 1) and the other is a number, the lane outputs the number.
- R6: When either operand is a signalling NaN (exponent all ones, top mantissa bit 0, mantissa non-zero), or both are NaN, the lane outputs the default quiet NaN (sign 0, exponent all ones, mantissa MSB 1, other bits 0). `invalid` is 1 if this happens in at least one active lane, and 0 otherwise.
- R7: Comparing +0 with -0 in either order gives +0.
- R8: Size code 0 sets `undef_op`, leaves the first source unchanged on `result` and keeps `invalid` at 0.
- R9: `out_valid` is 1 exactly one cycle after a cycle with `in_valid` high, and 0 otherwise. `result` holds its value while no operation is started.
- R10: A synchronous active-high `rst` clears `result`, `out_valid`, `undef_op` and `invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Starts an operation on the current inputs |
| size_code | input | 2 | Element size select (0 illegal, 1 = 16, 2 = 32, 3 = 64 bits) |
| src_a | input | VEC_W | First source and old destination value |
| src_b | input | VEC_W | Second source |
| pred | input | VEC_W/8 | Predicate mask, one bit per byte |
| out_valid | output | 1 | Result valid strobe |
| result | output | VEC_W | Merged destination vector |
| undef_op | output | 1 | Illegal size code was given |
| invalid | output | 1 | An active lane produced the default NaN |

## Verification
All state sits in a single output register stage, so any wrong internal value is visible at `result` or at the flags in the cycle after the strobe. Nothing is held back to show up later. The tests drive lane patterns whose correct answers differ by lane parity, by active predicate bit and by NaN class. A mix-up between the two sources, a wrong predicate index or a wrong NaN rule therefore changes a specific lane of that one output word. The hold and strobe behaviour is checked in the idle cycles that follow each operation.

// File: rtl/pairmax_pkg.sv
package pairmax_pkg;
    typedef enum logic [1:0] {
        SZ_BAD  = 2'd0,
        SZ_HALF = 2'd1,
        SZ_SNGL = 2'd2,
        SZ_DBL  = 2'd3
    } elem_size_e;

    function automatic int exp_bits(input int k);
        return (k == 0) ? 5 : (k == 1) ? 8 : 11;
    endfunction

    function automatic int man_bits(input int k);
        return (k == 0) ? 10 : (k == 1) ? 23 : 52;
    endfunction
endpackage

// File: rtl/pairmax_fpmax.sv
module pairmax_fpmax #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    output logic [W-1:0] max_o,
    output logic         nan_dflt_o
);
    localparam logic [W-1:0] QNAN_DFLT = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic x_nan, y_nan, x_sig, y_sig, x_wins;
    logic [W-2:0] mag_x, mag_y;

    always_comb begin
        mag_x = op_x[W-2:0];
        mag_y = op_y[W-2:0];
        x_nan = (&op_x[W-2 -: EXP_W]) && (|op_x[MAN_W-1:0]);
        y_nan = (&op_y[W-2 -: EXP_W]) && (|op_y[MAN_W-1:0]);
        x_sig = x_nan && !op_x[MAN_W-1];
        y_sig = y_nan && !op_y[MAN_W-1];

        // sign decides first, so +0 beats -0
        if (op_x[W-1] != op_y[W-1]) begin
            x_wins = !op_x[W-1];
        end else if (!op_x[W-1]) begin
            x_wins = mag_x > mag_y;
        end else begin
            x_wins = mag_x < mag_y;
        end

        nan_dflt_o = 1'b0;
        if (x_sig || y_sig || (x_nan && y_nan)) begin
            max_o      = QNAN_DFLT;
            nan_dflt_o = 1'b1;
        end else if (x_nan) begin
            max_o = op_y;
        end else if (y_nan) begin
            max_o = op_x;
        end else begin
            max_o = x_wins ? op_x : op_y;
        end
    end
endmodule

// File: rtl/pairmax_lanes.sv
module pairmax_lanes #(
    parameter int VEC_W = 128,
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int ESZ   = 1 + EXP_W + MAN_W,
    localparam int LANES = VEC_W / ESZ
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [LANES-1:0] lane_on,
    output logic [VEC_W-1:0] merged_o,
    output logic             invalid_o
);
    logic [LANES-1:0] lane_inv;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        logic [ESZ-1:0] opx, opy, mx;
        logic           nd;

        if (e % 2 == 0) begin : g_even
            assign opx = src_a[e*ESZ +: ESZ];
            assign opy = src_a[(e+1)*ESZ +: ESZ];
        end else begin : g_odd
            assign opx = src_b[(e-1)*ESZ +: ESZ];
            assign opy = src_b[e*ESZ +: ESZ];
        end

        pairmax_fpmax #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_max (
            .op_x       (opx),
            .op_y       (opy),
            .max_o      (mx),
            .nan_dflt_o (nd)
        );

        assign merged_o[e*ESZ +: ESZ] = lane_on[e] ? mx : src_a[e*ESZ +: ESZ];
        assign lane_inv[e]            = lane_on[e] && nd;
    end

    assign invalid_o = |lane_inv;
endmodule

// File: rtl/pairmax_unit.sv
module pairmax_unit
    import pairmax_pkg::*;
#(
    parameter int VEC_W = 128,
    localparam int PRED_W = VEC_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        size_code,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [PRED_W-1:0] pred,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result,
    output logic              undef_op,
    output logic              invalid
);
    typedef struct packed {
        logic             valid;
        logic             undef;
        logic             inv;
        logic [VEC_W-1:0] data;
    } out_s;

    out_s state_d, state_q;

    logic [2:0][VEC_W-1:0] width_res;
    logic [2:0]            width_inv;

    for (genvar k = 0; k < 3; k++) begin : g_width
        localparam int EW    = exp_bits(k);
        localparam int MW    = man_bits(k);
        localparam int ESZ   = 1 + EW + MW;
        localparam int LANES = VEC_W / ESZ;
        localparam int BYTES = ESZ / 8;

        logic [LANES-1:0] lane_on;
        for (genvar j = 0; j < LANES; j++) begin : g_pick
            assign lane_on[j] = pred[j*BYTES];
        end

        pairmax_lanes #(.VEC_W(VEC_W), .EXP_W(EW), .MAN_W(MW)) u_lanes (
            .src_a     (src_a),
            .src_b     (src_b),
            .lane_on   (lane_on),
            .merged_o  (width_res[k]),
            .invalid_o (width_inv[k])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        state_d.undef = 1'b0;
        state_d.inv   = 1'b0;
        if (in_valid) begin
            unique case (elem_size_e'(size_code))
                SZ_HALF: begin
                    state_d.data = width_res[0];
                    state_d.inv  = width_inv[0];
                end
                SZ_SNGL: begin
                    state_d.data = width_res[1];
                    state_d.inv  = width_inv[1];
                end
                SZ_DBL: begin
                    state_d.data = width_res[2];
                    state_d.inv  = width_inv[2];
                end
                default: begin
                    state_d.data  = src_a;
                    state_d.undef = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.data;
    assign undef_op  = state_q.undef;
    assign invalid   = state_q.inv;
endmodule

// File: rtl/pairmax_checker.sv
module pairmax_checker #(
    parameter int VEC_W = 128,
    localparam int PRED_W = VEC_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        size_code,
    input logic [VEC_W-1:0]  src_a,
    input logic [PRED_W-1:0] pred,
    input logic              out_valid,
    input logic [VEC_W-1:0]  result,
    input logic              undef_op,
    input logic              invalid
);
    p_done_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    p_bad_size_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code == 2'd0) |=> (undef_op && !invalid && result == $past(src_a)));

    p_undef_only_done_r8: assert property (@(posedge clk) disable iff (rst)
        undef_op |-> out_valid);

    p_no_lanes_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pred == '0) |=> (result == $past(src_a) && !invalid));

    p_inv_only_done_r6: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (out_valid && !undef_op));
endmodule

bind pairmax_unit pairmax_checker #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .size_code (size_code),
    .src_a     (src_a),
    .pred      (pred),
    .out_valid (out_valid),
    .result    (result),
    .undef_op  (undef_op),
    .invalid   (invalid)
);

// File: tb/pairmax_unit_test.sv
`timescale 1ns/1ps
module pairmax_unit_test;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    size_code = 2'd0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [15:0]   pred = '0;
    logic          out_valid, undef_op, invalid;
    logic [VW-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pairmax_unit #(.VEC_W(VW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
        .src_a(src_a), .src_b(src_b), .pred(pred),
        .out_valid(out_valid), .result(result), .undef_op(undef_op), .invalid(invalid)
    );

    task automatic chk(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // drive on a falling edge, sample on the falling edge after the capturing edge
    task automatic run_op(input logic [1:0] sz, input logic [VW-1:0] a,
                          input logic [VW-1:0] b, input logic [15:0] p);
        @(negedge clk);
        size_code = sz; src_a = a; src_b = b; pred = p; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 result", result, '0);
        chk("R10 out_valid", VW'(out_valid), '0);
        chk("R10 undef_op", VW'(undef_op), '0);
        chk("R10 invalid", VW'(invalid), '0);
    endtask

    task automatic t_single_full();
        run_op(2'd2, {32'hBF800000, 32'hC0400000, 32'h40000000, 32'h3F800000},
                     {32'hC0E00000, 32'h3F000000, 32'h40800000, 32'h40A00000}, 16'hFFFF);
        chk("R9 out_valid", VW'(out_valid), 1);
        chk("R2 even lanes", {result[95:64], result[31:0]}, {32'hBF800000, 32'h40000000});
        chk("R3 odd lanes", {result[127:96], result[63:32]}, {32'h3F000000, 32'h40A00000});
        chk("R1 32-bit layout", result, {32'h3F000000, 32'hBF800000, 32'h40A00000, 32'h40000000});
    endtask

    task automatic t_single_pred();
        run_op(2'd2, {32'hBF800000, 32'hC0400000, 32'h40000000, 32'h3F800000},
                     {32'hC0E00000, 32'h3F000000, 32'h40800000, 32'h40A00000}, 16'h1012);
        chk("R4 predicate merge", result, {32'h3F000000, 32'hC0400000, 32'h40A00000, 32'h3F800000});
    endtask

    task automatic t_half_nan();
        run_op(2'd1, {16'h0000, 16'h8000, 16'h8000, 16'h0000, 16'h3C00, 16'h7C01, 16'h3C00, 16'h7E00},
                     {16'hFC00, 16'hC000, 16'h0000, 16'h8000, 16'hFE00, 16'h7E00, 16'h7E00, 16'h4000},
                     16'hFFFF);
        chk("R5 qNaN loses", result[31:0], {16'h4000, 16'h3C00});
        chk("R6 default NaN", result[63:32], {16'h7E00, 16'h7E00});
        chk("R6 invalid set", VW'(invalid), 1);
        chk("R7 signed zero", result[111:64], {16'h0000, 16'h0000, 16'h0000});
        chk("R1 16-bit top lane", result[127:112], VW'(16'hC000));
    endtask

    task automatic t_half_masked_nan();
        run_op(2'd1, {16'h0000, 16'h8000, 16'h8000, 16'h0000, 16'h3C00, 16'h7C01, 16'h3C00, 16'h7E00},
                     {16'hFC00, 16'hC000, 16'h0000, 16'h8000, 16'hFE00, 16'h7E00, 16'h7E00, 16'h4000},
                     16'hFFAF);
        chk("R6 inactive no invalid", VW'(invalid), 0);
        chk("R4 inactive keep", result,
            {16'hC000, 16'h0000, 16'h0000, 16'h0000, 16'h3C00, 16'h7C01, 16'h4000, 16'h3C00});
    endtask

    task automatic t_double();
        run_op(2'd3, {64'hC000000000000000, 64'h3FF0000000000000},
                     {64'h4008000000000000, 64'h7FF8000000000000}, 16'h0101);
        chk("R1 R5 64-bit", result, {64'h4008000000000000, 64'h3FF0000000000000});
        chk("R6 no invalid", VW'(invalid), 0);
    endtask

    task automatic t_undef();
        logic [VW-1:0] a;
        a = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        run_op(2'd0, a, ~a, 16'hFFFF);
        chk("R8 undef_op", VW'(undef_op), 1);
        chk("R8 result kept", result, a);
        chk("R8 no invalid", VW'(invalid), 0);
        @(negedge clk);
        chk("R9 idle out_valid", VW'(out_valid), 0);
        chk("R9 idle hold", result, a);
        chk("R8 undef clears", VW'(undef_op), 0);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_full();
        t_single_pred();
        t_half_nan();
        t_half_masked_nan();
        t_double();
        t_undef();
        t_reset_again();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule